// File: doc/BRIEF.md
# Timed UART Break Generator

This block forces a UART transmit line low (break) for a number of millisecond ticks set by a writable count register. Software loads a count. On a later tick the break begins, and each tick after that takes one off the count. When the count reaches zero the line is released.

The top code (all ones) keeps the line in break with no countdown until some other value is written. Writing zero cancels the break. Writing a new nonzero value during a break restarts the countdown from that value. A break never starts while the shifter is still sending a character: the start waits for a tick on which the transmitter is idle.

The current count can be read at any time. Outside a break, the shifter's serial output passes straight through to the pin.

Top module: `uart_brk_gen`

## Requirements
- R1: After reset the count is 0, no break is active, and `tx_o` equals `tx_ser_i`.
- R2: A write loads `wr_data_i` into the count on the next clock edge, and `count_o` always shows the stored count. A break begins on the edge of the first tick with a nonzero count, no write, and `tx_busy_i` low. The count does not decrement on that start tick.
- R3: Each tick during a break, with no write in the same cycle and a count other than 0xFFF, decrements the count by one. The break ends on the edge where the count reaches 0. A count of N therefore keeps `brk_active_o` high on exactly N ticks.
- R4: Writing a nonzero value other than 0xFFF during a break keeps the break active, and the countdown continues from the new value.
- R5: Count 0xFFF (all ones) never decrements. It holds the break until a different value is written.
- R6: Writing 0 ends an active break on the next clock edge and cancels a pending one.
- R7: A tick while `tx_busy_i` is high does not start a break. The break starts on the first later tick with `tx_busy_i` low.
- R8: `tx_o` is 0 while `brk_active_o` is high, and equals `tx_ser_i` otherwise.
- R9: A write in the same cycle as a tick takes effect, and that tick is ignored: no decrement and no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Count register write strobe |
| wr_data_i | input | 12 | Count write data |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| tx_busy_i | input | 1 | Shifter is sending a character |
| tx_ser_i | input | 1 | Shifter serial output |
| tx_o | output | 1 | Transmit pin level |
| brk_active_o | output | 1 | Break is being driven |
| count_o | output | 12 | Current count value |

## Verification
The bench counts the ticks spent in break against the loaded count. A design that decrements on the start tick gives one tick too few, and a late release gives one too many.

It reloads during a break and writes 0xFFF. A design that dropped the break on a reload, or kept counting down the hold code, would release the line early.

It raises busy across ticks, which catches a break that cuts into a character in flight. It also lands writes on tick cycles, which exposes a lost write or a double update.

Long runs of random stimulus are compared cycle by cycle against a bench model of these rules.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef enum logic {BRK_IDLE = 1'b0, BRK_ON = 1'b1} brk_state_e;
endpackage

// File: rtl/uart_brk_cnt.sv
module uart_brk_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             tick_ms_i,
  input  logic             active_i,
  output logic             dec_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] HOLD = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign dec_o = tick_ms_i && !wr_en_i && active_i && cnt_q != HOLD && cnt_q != '0;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_en_i) cnt_q <= wr_data_i;
    else if (dec_o)   cnt_q <= cnt_q - 1'b1;
  end

  assert_step_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) && cnt_q != $past(cnt_q) |-> cnt_q == $past(cnt_q) - 1'b1);
  assert_hold_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == HOLD && !wr_en_i |=> cnt_q == HOLD);
endmodule

// File: rtl/uart_brk_ctrl.sv
module uart_brk_ctrl
  import uart_brk_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             tick_ms_i,
  input  logic             tx_busy_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dec_i,
  output logic             active_o
);
  brk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_en_i) begin
      // a write never starts a break, only keeps or cancels one
      if (wr_data_i == '0) state_d = BRK_IDLE;
    end else if (state_q == BRK_ON) begin
      if (dec_i && cnt_i == CNT_W'(1)) state_d = BRK_IDLE;
    end else if (tick_ms_i && !tx_busy_i && cnt_i != '0) begin
      state_d = BRK_ON;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= BRK_IDLE;
    else         state_q <= state_d;
  end

  assign active_o = (state_q == BRK_ON);

  assert_start_idle_tx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o && tick_ms_i && tx_busy_i |=> !active_o);
  assert_zero_write_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i == '0 |=> !active_o);
  assert_active_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> cnt_i != '0);
endmodule

// File: rtl/uart_brk_gen.sv
module uart_brk_gen #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             tick_ms_i,
  input  logic             tx_busy_i,
  input  logic             tx_ser_i,
  output logic             tx_o,
  output logic             brk_active_o,
  output logic [CNT_W-1:0] count_o
);
  logic dec;
  logic active;

  uart_brk_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .tick_ms_i,
    .active_i(active), .dec_o(dec), .cnt_o(count_o)
  );

  uart_brk_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .tick_ms_i, .tx_busy_i,
    .cnt_i(count_o), .dec_i(dec), .active_o(active)
  );

  assign brk_active_o = active;
  assign tx_o         = tx_ser_i & ~active;

  assert_pin_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_active_o |-> !tx_o);
endmodule

// File: tb/uart_brk_gen_test.sv
module uart_brk_gen_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [11:0] wr_data = '0;
  logic        tick = 0;
  logic        busy = 0;
  logic        ser = 1;
  logic        tx;
  logic        act;
  logic [11:0] cnt;

  int n_chk = 0;
  int n_bad = 0;
  logic        m_act = 0;
  logic [11:0] m_cnt = '0;

  always #5 clk = ~clk;

  uart_brk_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .tick_ms_i(tick), .tx_busy_i(busy), .tx_ser_i(ser),
    .tx_o(tx), .brk_active_o(act), .count_o(cnt)
  );

  function automatic logic [12:0] next_state(logic a, logic [11:0] c, logic w,
                                             logic [11:0] d, logic t, logic b);
    logic na;
    logic [11:0] nc;
    na = a;
    nc = c;
    if (w) begin
      nc = d;
      na = a && d != 0;
    end else if (a) begin
      if (t && c != 12'hFFF && c != 0) begin
        nc = c - 1;
        if (nc == 0) na = 0;
      end
    end else if (t && !b && c != 0) begin
      na = 1;
    end
    return {na, nc};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
    end
  endtask

  // drive at negedge, clock, compare at next negedge
  task automatic cyc(logic w, logic [11:0] d, logic t, logic b, logic s);
    logic [12:0] nx;
    wr_en = w; wr_data = d; tick = t; busy = b; ser = s;
    nx = next_state(m_act, m_cnt, w, d, t, b);
    @(posedge clk);
    m_act = nx[12];
    m_cnt = nx[11:0];
    @(negedge clk);
    check("R2 count", cnt, m_cnt);
    check("R3 active", act, m_act);
    check("R8 pin", tx, m_act ? 1'b0 : s);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1);
  endtask

  // count ticks seen with break active, ticks every 4 cycles
  task automatic run_ticks(int n_ticks, output int in_brk);
    in_brk = 0;
    for (int i = 0; i < n_ticks; i++) begin
      if (act) in_brk++;
      cyc(0, 0, 1, 0, 1);
      idle(3);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    check("R1 count", cnt, 0);
    check("R1 active", act, 0);
    ser = 0; #1 check("R1 pass low", tx, 0);
    ser = 1; #1 check("R1 pass high", tx, 1);
    @(negedge clk);
    rst_n = 1;
    idle(2);

    // R2 / R3: count 5 gives exactly 5 ticks in break
    cyc(1, 12'd5, 0, 0, 1);
    check("R2 no start on write", act, 0);
    run_ticks(10, k);
    check("R3 ticks in break", k, 5);
    check("R3 released", act, 0);

    // R4: reload mid count
    cyc(1, 12'd4, 0, 0, 1);
    run_ticks(3, k);
    check("R4 still active", act, 1);
    check("R4 count", cnt, 2);
    cyc(1, 12'd6, 0, 0, 1);
    check("R4 active after reload", act, 1);
    run_ticks(10, k);
    check("R4 ticks after reload", k, 6);

    // R5: hold code
    cyc(1, 12'hFFF, 0, 0, 1);
    run_ticks(20, k);
    check("R5 held ticks", k, 19);
    check("R5 count held", cnt, 12'hFFF);
    check("R5 still active", act, 1);
    // R6: zero cancels
    cyc(1, 12'd0, 0, 0, 1);
    check("R6 ended", act, 0);
    check("R8 pin released", tx, 1);

    // R7: busy delays start
    cyc(1, 12'd2, 0, 0, 1);
    cyc(0, 0, 1, 1, 0);
    check("R7 no start while busy", act, 0);
    idle(3);
    cyc(0, 0, 1, 1, 1);
    check("R7 still waiting", act, 0);
    cyc(0, 0, 1, 0, 1);
    check("R7 started", act, 1);
    check("R7 count kept", cnt, 2);

    // R9: write on tick cycle
    cyc(1, 12'd9, 1, 0, 1);
    check("R9 write wins", cnt, 9);
    check("R9 stays active", act, 1);
    cyc(1, 12'd0, 0, 0, 1);
    cyc(1, 12'd3, 1, 0, 1);
    check("R9 no start on write tick", act, 0);
    check("R9 loaded", cnt, 3);
    cyc(1, 12'd0, 0, 0, 1);

    // random mix against model
    for (int i = 0; i < 4000; i++) begin
      logic w, t, b, s;
      logic [11:0] d;
      int r;
      w = ($urandom_range(0, 29) == 0);
      t = ($urandom_range(0, 5) == 0);
      b = ($urandom_range(0, 3) == 0);
      s = $urandom_range(0, 1);
      r = $urandom_range(0, 9);
      d = (r == 0) ? 12'h000 : (r == 1) ? 12'hFFF : (r == 2) ? 12'hFFE : (r == 3) ? 12'd1
                  : 12'($urandom_range(1, 12));
      cyc(w, d, t, b, s);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule